// File: doc/BRIEF.md
# Event-Selectable Performance Monitor Counter

This block is one hardware performance counter. A small control register picks one of 256 single-bit event lines and sets how that line is counted. In level mode the 64-bit counter gains one on every clock cycle the chosen line is high. In edge mode it gains one only on a low-to-high change of that line. Counting happens only while both the local enable bit in the control register and the global enable input are high.

Software reaches both registers over a plain register bus. A one-bit address picks the register: 0 is the control word and 1 is the counter. Writes take effect at the next clock edge. Read data is combinational and appears in the same cycle. When the counter wraps from all-ones to zero, the block can raise a one-cycle interrupt request. The counter keeps running after the wrap.

The bus carries single register accesses and has no data stream, so there is no valid/ready handshake and no back-pressure. Every pin is a plain control or status signal.

Top module: `evt_perf_counter`

## Requirements
- R1: After reset the control word reads 0, the counter reads 0, and irq is low.
- R2: The control word has these fields: event select in bits 7:0, edge mode in bit 18, interrupt enable in bit 20, and local enable in bit 22. Every other bit reads as 0, and writes to those bits have no effect. Control reads are zero-extended to 64 bits.
- R3: A write with address 1 loads all 64 bits of the counter, and a read with address 1 returns the counter value in the same cycle.
- R4: In level mode (bit 18 = 0) the counter gains one for each clock cycle in which the selected event input is high. Event inputs that are not selected have no effect.
- R5: In edge mode (bit 18 = 1) the counter gains one only in a cycle where the selected event is high and was low in the cycle before.
- R6: The counter changes only when the local enable (bit 22) and the global enable input are both 1, except when software writes it.
- R7: The edge history is updated while counting is disabled, so an event that is already high when counting is enabled is not counted as an edge.
- R8: After the event select changes, a new event that is already high does not produce an edge in the first cycle.
- R9: A counter write in the same cycle as a countable event loads the written value, and that event is dropped.
- R10: A count at all-ones wraps the counter to 0, and counting continues from there. With the interrupt enable set, irq is high for exactly one cycle, in the cycle the counter first reads 0.
- R11: With the interrupt enable clear, a wrap never raises irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (synchronous to clk) |
| glb_en | input | 1 | Global counting enable from outside the block |
| events | input | 256 | Event lines, one bit per event |
| bus_addr | input | 1 | Register select: 0 = control, 1 = counter |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data for the selected register, valid in the same cycle |
| irq | output | 1 | One-cycle overflow interrupt request |

## Verification
The bench drives the wrap from all-ones. A design that raised irq one cycle late, held it for two cycles, or ignored the interrupt-enable bit would be caught there. It holds an event high across a change of enable and across a change of event select. A design that froze its edge history while disabled, or kept the old event's history, would count a false edge there. It also writes the counter in the same cycle as a live event. A design that let the increment win would read one higher. Finally, it writes ones into every control bit, which exposes any stored reserved bit or any misplaced field.

// File: rtl/epc_pkg.sv
package epc_pkg;
  localparam int SEL_W    = 8;
  localparam int NUM_EVT  = 1 << SEL_W;
  localparam int EDGE_BIT = 18;
  localparam int IRQ_BIT  = 20;
  localparam int EN_BIT   = 22;

  typedef struct packed {
    logic             en;
    logic             irq_en;
    logic             edge_md;
    logic [SEL_W-1:0] sel;
  } ctrl_t;
endpackage

// File: rtl/epc_ctrl_reg.sv
module epc_ctrl_reg
  import epc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  ctrl_t wr_fields,
  output ctrl_t ctrl_q,
  output ctrl_t ctrl_nxt
);
  // Next-cycle value is exported so the event path can prime its history.
  always_comb begin
    ctrl_nxt = ctrl_q;
    if (wr_en) ctrl_nxt = wr_fields;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_nxt;
  end
endmodule

// File: rtl/epc_event_path.sv
module epc_event_path
  import epc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] events,
  input  logic [SEL_W-1:0]   sel_q,
  input  logic [SEL_W-1:0]   sel_nxt,
  input  logic               edge_md,
  output logic               hit
);
  logic cur_lvl;
  logic nxt_lvl;
  logic hist_q;

  assign cur_lvl = events[sel_q];
  // History samples the event that will be selected in the next cycle, so a
  // change of selection never compares against the old event's level.
  assign nxt_lvl = events[sel_nxt];

  always_ff @(posedge clk) begin
    if (!rst_n) hist_q <= 1'b0;
    else        hist_q <= nxt_lvl;
  end

  assign hit = edge_md ? (cur_lvl & ~hist_q) : cur_lvl;
endmodule

// File: rtl/epc_count_reg.sv
module epc_count_reg #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap
);
  // A software load takes priority over an increment in the same cycle.
  assign wrap = inc & ~load & (&cnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (inc)  cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/evt_perf_counter.sv
module evt_perf_counter
  import epc_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int BUS_W  = 64,
  parameter int CTRL_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               glb_en,
  input  logic [NUM_EVT-1:0] events,
  input  logic               bus_addr,
  input  logic               bus_wr,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  output logic               irq
);
  logic              ctrl_wr;
  logic              cnt_wr;
  ctrl_t             wr_fields;
  ctrl_t             ctrl_q;
  ctrl_t             ctrl_nxt;
  logic              hit;
  logic              inc;
  logic              wrap;
  logic [CNT_W-1:0]  cnt_q;
  logic [CTRL_W-1:0] ctrl_word;

  assign ctrl_wr = bus_wr & ~bus_addr;
  assign cnt_wr  = bus_wr &  bus_addr;

  assign wr_fields.sel     = bus_wdata[SEL_W-1:0];
  assign wr_fields.edge_md = bus_wdata[EDGE_BIT];
  assign wr_fields.irq_en  = bus_wdata[IRQ_BIT];
  assign wr_fields.en      = bus_wdata[EN_BIT];

  epc_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (ctrl_wr),
    .wr_fields (wr_fields),
    .ctrl_q    (ctrl_q),
    .ctrl_nxt  (ctrl_nxt)
  );

  epc_event_path u_evt (
    .clk     (clk),
    .rst_n   (rst_n),
    .events  (events),
    .sel_q   (ctrl_q.sel),
    .sel_nxt (ctrl_nxt.sel),
    .edge_md (ctrl_q.edge_md),
    .hit     (hit)
  );

  assign inc = ctrl_q.en & glb_en & hit;

  epc_count_reg #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_wr),
    .load_val (bus_wdata[CNT_W-1:0]),
    .inc      (inc),
    .cnt_q    (cnt_q),
    .wrap     (wrap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= wrap & ctrl_q.irq_en;
  end

  always_comb begin
    ctrl_word              = '0;
    ctrl_word[SEL_W-1:0]   = ctrl_q.sel;
    ctrl_word[EDGE_BIT]    = ctrl_q.edge_md;
    ctrl_word[IRQ_BIT]     = ctrl_q.irq_en;
    ctrl_word[EN_BIT]      = ctrl_q.en;
  end

  assign bus_rdata = bus_addr ? BUS_W'(cnt_q) : BUS_W'(ctrl_word);
endmodule

// File: rtl/epc_checker.sv
module epc_checker #(
  parameter int CNT_W = 64,
  parameter int BUS_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             glb_en,
  input logic             bus_addr,
  input logic             bus_wr,
  input logic [BUS_W-1:0] bus_wdata,
  input logic [BUS_W-1:0] bus_rdata,
  input logic             irq,
  input logic [CNT_W-1:0] cnt_q,
  input logic             loc_en,
  input logic             irq_en
);
  localparam logic [BUS_W-1:0] LIVE_MASK = BUS_W'(64'h0054_00FF);

  logic cnt_write;
  assign cnt_write = bus_wr & bus_addr;

  a_r6_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!(loc_en && glb_en) && !cnt_write) |=> $stable(cnt_q));

  a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_write |=> (cnt_q == $past(bus_wdata[CNT_W-1:0])));

  a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_write |=> (cnt_q == $past(cnt_q) || cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  a_r10_irq_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cnt_q == '0));

  a_r10_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r11_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(irq_en));

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_addr |-> ((bus_rdata & ~LIVE_MASK) == '0));
endmodule

bind evt_perf_counter epc_checker #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .glb_en    (glb_en),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .cnt_q     (cnt_q),
  .loc_en    (ctrl_q.en),
  .irq_en    (ctrl_q.irq_en)
);

// File: tb/sim_evt_perf_counter.sv
`timescale 1ns/1ps
module sim_evt_perf_counter;
  localparam logic [63:0] C_EN  = 64'h0040_0000;  // bit 22
  localparam logic [63:0] C_IRQ = 64'h0010_0000;  // bit 20
  localparam logic [63:0] C_EDG = 64'h0004_0000;  // bit 18
  localparam logic [63:0] ONES  = '1;

  // {sel[8], edge[1], glb[1], en[1], pattern[8] (bit0 first), expected[8]}
  localparam logic [26:0] VEC [8] = '{
    {8'd5,   1'b0, 1'b1, 1'b1, 8'b1011_0110, 8'd5},
    {8'd5,   1'b1, 1'b1, 1'b1, 8'b1011_0110, 8'd3},
    {8'd200, 1'b0, 1'b1, 1'b1, 8'hFF,        8'd8},
    {8'd200, 1'b1, 1'b1, 1'b1, 8'hFF,        8'd1},
    {8'd0,   1'b1, 1'b1, 1'b1, 8'b0101_0101, 8'd4},
    {8'd255, 1'b0, 1'b0, 1'b1, 8'hFF,        8'd0},
    {8'd254, 1'b0, 1'b1, 1'b0, 8'hFF,        8'd0},
    {8'd17,  1'b0, 1'b1, 1'b1, 8'h0F,        8'd4}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         glb_en = 1'b0;
  logic [255:0] ev = '0;
  logic         bus_addr = 1'b0;
  logic         bus_wr = 1'b0;
  logic [63:0]  bus_wdata = '0;
  logic [63:0]  bus_rdata;
  logic         irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  evt_perf_counter u0 (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .events(ev),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic wr(input logic a, input logic [63:0] d);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [63:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(1'b0, v); chk("R1 ctrl", v, 64'h0);
    rd(1'b1, v); chk("R1 cnt", v, 64'h0);
    chk("R1 irq", {63'h0, irq}, 64'h0);

    // Vector table: R4 / R5 / R6
    for (int i = 0; i < 8; i++) begin
      logic [7:0] sel, pat, exp;
      logic edg, g, en;
      {sel, edg, g, en, pat, exp} = VEC[i];
      ev = '0;
      glb_en = g;
      wr(1'b0, {56'h0, sel} | (edg ? C_EDG : 64'h0) | (en ? C_EN : 64'h0));
      wr(1'b1, 64'h0);
      for (int k = 0; k < 8; k++) begin
        ev = '0;
        ev[sel] = pat[k];
        ev[sel ^ 8'd1] = 1'b1;  // unselected neighbour kept high (R4)
        @(negedge clk);
      end
      ev = '0;
      rd(1'b1, v);
      chk(edg ? "R5 edge vector" : (g && en) ? "R4 level vector" : "R6 enable vector",
          v, {56'h0, exp});
    end

    // R2 field layout and ignored bits
    glb_en = 1'b0;
    wr(1'b0, ONES);
    rd(1'b0, v); chk("R2 all ones", v, 64'h0054_00FF);
    wr(1'b0, 64'hFFFF_FFFF_FF8A_FF00 | C_EDG);
    rd(1'b0, v); chk("R2 edge only", v, 64'h0004_0000);

    // R3 full-width counter write
    wr(1'b1, 64'hDEAD_BEEF_0123_4567);
    rd(1'b1, v); chk("R3 cnt rw", v, 64'hDEAD_BEEF_0123_4567);

    // R9 write beats event
    glb_en = 1'b1; ev = '0;
    wr(1'b0, C_EN | 64'd3);
    ev[3] = 1'b1;
    wr(1'b1, 64'd100);
    rd(1'b1, v); chk("R9 write wins", v, 64'd100);
    @(negedge clk);
    rd(1'b1, v); chk("R9 counts after", v, 64'd101);

    // R10 wrap with interrupt
    ev = '0;
    wr(1'b0, C_EN | C_IRQ | 64'd3);
    ev[3] = 1'b1;
    wr(1'b1, ONES);
    rd(1'b1, v); chk("R10 at ones", v, ONES);
    @(negedge clk);
    rd(1'b1, v); chk("R10 wrapped", v, 64'h0);
    chk("R10 irq high", {63'h0, irq}, 64'h1);
    @(negedge clk);
    rd(1'b1, v); chk("R10 continues", v, 64'h1);
    chk("R10 irq single", {63'h0, irq}, 64'h0);

    // R11 wrap without interrupt
    ev = '0;
    wr(1'b0, C_EN | 64'd3);
    ev[3] = 1'b1;
    wr(1'b1, ONES);
    @(negedge clk);
    rd(1'b1, v); chk("R11 wrapped", v, 64'h0);
    chk("R11 no irq", {63'h0, irq}, 64'h0);

    // R7 history tracked while disabled
    ev = '0; glb_en = 1'b0;
    wr(1'b0, C_EN | C_EDG | 64'd9);
    wr(1'b1, 64'h0);
    ev[9] = 1'b1;
    repeat (3) @(negedge clk);
    glb_en = 1'b1;
    repeat (3) @(negedge clk);
    rd(1'b1, v); chk("R7 no false edge", v, 64'h0);
    ev[9] = 1'b0; @(negedge clk);
    ev[9] = 1'b1; @(negedge clk);
    rd(1'b1, v); chk("R7 real edge", v, 64'h1);

    // R8 selection change
    ev = '0;
    wr(1'b0, C_EN | C_EDG | 64'd10);
    wr(1'b1, 64'h0);
    ev[11] = 1'b1;
    @(negedge clk);
    wr(1'b0, C_EN | C_EDG | 64'd11);
    repeat (3) @(negedge clk);
    rd(1'b1, v); chk("R8 no false edge", v, 64'h0);
    ev[11] = 1'b0; @(negedge clk);
    ev[11] = 1'b1; @(negedge clk);
    rd(1'b1, v); chk("R8 real edge", v, 64'h1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule